// File: doc/BRIEF.md
# Speed-Scaled Fixed-Point Time Counter

This block keeps a free-running system time as a 64-bit fixed-point count. Each oscillator tick adds a programmable increment rather than one, so the count grows in fixed-point nanoseconds. Software reads the count through a two-word read port and turns it into nanoseconds with a single right shift. The shift amount is reported by the block on the `shift_o` port.

The oscillator period depends on the link speed. It is 6.4 ns at 10G and with no link, 64 ns at 1G and 640 ns at 100M. When the speed input changes, the block reloads the increment with the default for the new period and reports the matching shift. Each default is the period scaled by the largest power of two whose product still fits the increment field, with any fraction dropped. Software may overwrite the increment at any time, for example to trim the frequency. The field width is a parameter: 24 bits by default, and up to 31 bits.

The read port takes a snapshot of the whole count when the low word is read. A later read of the high word therefore belongs to the same instant.

Top module: `stc_timebase`

## Requirements
- R1: After reset the count is zero, `speed` is taken as 10G, the increment is 0xCCCCCC (for a 24-bit field) and `shift_o` is 21.
- R2: On each clock with `tick_i` high the count grows by the current increment, modulo 2^64; with `tick_i` low it holds.
- R3: The default increment and shift for each speed code are as follows. Code 3 (10G) and code 0 (no link) give 0xCCCCCC with shift 21. Code 2 (1G) gives 0x800000 with shift 17. Code 1 (100M) gives 0xA00000 with shift 14.
- R4: A change of the speed input reloads the increment and the shift one clock later, and leaves the accumulated count untouched.
- R5: A register write loads the increment with the written 32-bit value masked to the low INC_W bits; the upper bits read back as zero on `inc_o`.
- R6: A write in the same clock as a tick leaves that tick using the old increment; the new value is used from the next tick on, and the count is not reset by the write.
- R7: A read with `rd_hi_i` low returns count bits 31:0 on `rd_data_o` one clock later and snapshots all 64 bits; a read with `rd_hi_i` high returns bits 63:32 of that snapshot one clock later, whatever ticks came between.
- R8: If a write and a speed change arrive in the same clock, the written value wins and stays in place afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Oscillator tick enable, one per accumulate step |
| wr_en_i | input | 1 | Increment register write strobe |
| wr_data_i | input | 32 | Increment write data (masked to INC_W bits) |
| speed_i | input | 2 | Link speed: 0 none, 1 100M, 2 1G, 3 10G |
| rd_en_i | input | 1 | Read strobe |
| rd_hi_i | input | 1 | 0 reads the low word and snapshots, 1 reads the snapshot high word |
| rd_data_o | output | 32 | Read data, valid the clock after the strobe |
| inc_o | output | 32 | Current increment value |
| shift_o | output | 6 | Right shift that turns the count into nanoseconds |

## Verification
The assertions assume that `speed_i` carries one of the four codes and is held for several clocks once changed. They also assume that `rd_hi_i` matters only while `rd_en_i` is high, and that a high-word read follows a low-word read. The bench drives every input on the falling clock edge and changes the speed only while ticks and reads are idle. It always reads the low word before the high word, so each snapshot is defined before it is checked. One exception is deliberate: the R7 test lets ticks run between the two halves of a read, to show that the high word comes from the snapshot.

// File: rtl/stc_pkg.sv
package stc_pkg;

  typedef enum logic [1:0] {
    SPD_NONE = 2'd0,
    SPD_100M = 2'd1,
    SPD_1G   = 2'd2,
    SPD_10G  = 2'd3
  } stc_speed_e;

  // Oscillator period in tenths of a nanosecond for each speed code.
  function automatic int unsigned period_tenths(input stc_speed_e s);
    case (s)
      SPD_100M: return 6400;
      SPD_1G:   return 640;
      default:  return 64;
    endcase
  endfunction

  // Largest k with floor(period * 2^k) below 2^inc_w (period in ns).
  function automatic logic [5:0] shift_for(input int unsigned per, input int unsigned inc_w);
    logic [5:0] best;
    best = '0;
    for (int k = 0; k < 40; k++) begin
      if (((64'(per) << k) / 64'd10) < (64'd1 << inc_w)) best = 6'(k);
    end
    return best;
  endfunction

  function automatic logic [31:0] inc_for(input int unsigned per, input int unsigned inc_w);
    logic [63:0] v;
    v = (64'(per) << shift_for(per, inc_w)) / 64'd10;
    return v[31:0];
  endfunction

endpackage

// File: rtl/stc_incr_sel.sv
module stc_incr_sel #(
  parameter int unsigned INC_W = 24,
  parameter int unsigned REG_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  input  logic [1:0]       speed_i,
  output logic [REG_W-1:0] inc_o,
  output logic [5:0]       shift_o
);
  import stc_pkg::*;

  localparam logic [REG_W-1:0] INC_MASK = REG_W'((64'd1 << INC_W) - 64'd1);
  localparam logic [REG_W-1:0] RST_INC  = REG_W'(inc_for(period_tenths(SPD_10G), INC_W));

  stc_speed_e       speed_q;
  stc_speed_e       speed_new;
  logic [REG_W-1:0] inc_q;
  logic [REG_W-1:0] def_inc;
  logic             spd_chg;

  assign speed_new = stc_speed_e'(speed_i);
  assign spd_chg   = (speed_new != speed_q);
  assign def_inc   = REG_W'(inc_for(period_tenths(speed_new), INC_W));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      speed_q <= SPD_10G;
      inc_q   <= RST_INC;
    end else begin
      speed_q <= speed_new;
      if (wr_en_i)      inc_q <= wr_data_i & INC_MASK;
      else if (spd_chg) inc_q <= def_inc;
    end
  end

  assign inc_o   = inc_q;
  assign shift_o = shift_for(period_tenths(speed_q), INC_W);

  p_write_masked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i |=> inc_q == ($past(wr_data_i) & INC_MASK));
  p_speed_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (spd_chg && !wr_en_i) |=> inc_q == $past(def_inc));
  p_write_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (spd_chg && wr_en_i) |=> inc_q != $past(def_inc) || $past(wr_data_i & INC_MASK) == $past(def_inc));
  p_no_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!spd_chg && !wr_en_i) |=> $stable(inc_q));

endmodule

// File: rtl/stc_accum.sv
module stc_accum #(
  parameter int unsigned CNT_W = 64,
  parameter int unsigned REG_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic [REG_W-1:0] inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt_q <= '0;
    else if (tick_i) cnt_q <= cnt_q + CNT_W'(inc_i);
  end

  assign cnt_o = cnt_q;

  p_tick_adds_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tick_i |=> (cnt_q - $past(cnt_q)) == CNT_W'($past(inc_i)));
  p_idle_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> $stable(cnt_q));

endmodule

// File: rtl/stc_snap.sv
module stc_snap #(
  parameter int unsigned WORD_W = 32,
  localparam int unsigned CNT_W = 2 * WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en_i,
  input  logic              rd_hi_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic [WORD_W-1:0] rd_data_o
);
  logic [CNT_W-1:0]  snap_q;
  logic [WORD_W-1:0] rd_q;
  logic              rd_lo_ev;
  logic              rd_hi_ev;

  assign rd_lo_ev = rd_en_i && !rd_hi_i;
  assign rd_hi_ev = rd_en_i && rd_hi_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      snap_q <= '0;
      rd_q   <= '0;
    end else if (rd_lo_ev) begin
      snap_q <= cnt_i;
      rd_q   <= cnt_i[WORD_W-1:0];
    end else if (rd_hi_ev) begin
      rd_q   <= snap_q[CNT_W-1:WORD_W];
    end
  end

  assign rd_data_o = rd_q;

  p_lo_live_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_lo_ev |=> rd_data_o == $past(cnt_i[WORD_W-1:0]));
  p_hi_snapshot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hi_ev |=> rd_data_o == $past(snap_q[CNT_W-1:WORD_W]));
  p_snap_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_lo_ev |=> $stable(snap_q));

endmodule

// File: rtl/stc_timebase.sv
module stc_timebase #(
  parameter int unsigned INC_W  = 24,
  parameter int unsigned WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              wr_en_i,
  input  logic [WORD_W-1:0] wr_data_i,
  input  logic [1:0]        speed_i,
  input  logic              rd_en_i,
  input  logic              rd_hi_i,
  output logic [WORD_W-1:0] rd_data_o,
  output logic [WORD_W-1:0] inc_o,
  output logic [5:0]        shift_o
);
  localparam int unsigned CNT_W = 2 * WORD_W;

  logic [WORD_W-1:0] inc_w;
  logic [CNT_W-1:0]  cnt_w;

  initial begin
    a_inc_width_r5: assert (INC_W >= 8 && INC_W <= 31);
  end

  stc_incr_sel #(.INC_W(INC_W), .REG_W(WORD_W)) u_incr (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
    .speed_i(speed_i), .inc_o(inc_w), .shift_o(shift_o)
  );

  stc_accum #(.CNT_W(CNT_W), .REG_W(WORD_W)) u_accum (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .inc_i(inc_w), .cnt_o(cnt_w)
  );

  stc_snap #(.WORD_W(WORD_W)) u_snap (
    .clk(clk), .rst_n(rst_n), .rd_en_i(rd_en_i), .rd_hi_i(rd_hi_i),
    .cnt_i(cnt_w), .rd_data_o(rd_data_o)
  );

  assign inc_o = inc_w;

  p_speed_keeps_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && $past(speed_i) != speed_i) |=> $stable(cnt_w));

endmodule

// File: tb/test_stc_timebase.sv
module test_stc_timebase;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_i = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [31:0] wr_data_i = '0;
  logic [1:0]  speed_i = 2'd3;
  logic        rd_en_i = 1'b0;
  logic        rd_hi_i = 1'b0;
  logic [31:0] rd_data_o;
  logic [31:0] inc_o;
  logic [5:0]  shift_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [63:0] model;

  always #10 clk = ~clk;

  stc_timebase i_stc_timebase (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wr_en_i(wr_en_i),
    .wr_data_i(wr_data_i), .speed_i(speed_i), .rd_en_i(rd_en_i),
    .rd_hi_i(rd_hi_i), .rd_data_o(rd_data_o), .inc_o(inc_o), .shift_o(shift_o)
  );

  // {speed, ticks, expected increment, expected shift}
  localparam logic [47:0] VEC [6] = '{
    {2'd3, 8'd5, 32'h00CC_CCCC, 6'd21},
    {2'd2, 8'd7, 32'h0080_0000, 6'd17},
    {2'd1, 8'd3, 32'h00A0_0000, 6'd14},
    {2'd0, 8'd4, 32'h00CC_CCCC, 6'd21},
    {2'd2, 8'd2, 32'h0080_0000, 6'd17},
    {2'd3, 8'd6, 32'h00CC_CCCC, 6'd21}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    tick_i = 1'b1;
    repeat (n) @(negedge clk);
    tick_i = 1'b0;
  endtask

  task automatic read64(output logic [63:0] v);
    rd_en_i = 1'b1; rd_hi_i = 1'b0;
    @(negedge clk);
    v[31:0] = rd_data_o;
    rd_hi_i = 1'b1;
    @(negedge clk);
    v[63:32] = rd_data_o;
    rd_en_i = 1'b0; rd_hi_i = 1'b0;
  endtask

  task automatic write_inc(input logic [31:0] d);
    wr_en_i = 1'b1; wr_data_i = d;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  initial begin
    logic [63:0] rv;
    logic [31:0] lo_part;
    logic [63:0] snap;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk("R1 inc", 64'(inc_o), 64'h00CC_CCCC);
    chk("R1 shift", 64'(shift_o), 64'd21);
    read64(rv);
    chk("R1 count", rv, 64'd0);
    model = 64'd0;

    // R2 R3 R4: speed table walk, count kept across speed changes
    foreach (VEC[i]) begin
      speed_i = VEC[i][47:46];
      repeat (2) @(negedge clk);
      chk("R3 inc", 64'(inc_o), 64'(VEC[i][37:6]));
      chk("R3 shift", 64'(shift_o), 64'(VEC[i][5:0]));
      read64(rv);
      chk("R4 count kept", rv, model);
      ticks(int'(VEC[i][45:38]));
      model = model + 64'(VEC[i][45:38]) * 64'(VEC[i][37:6]);
      read64(rv);
      chk("R2 count", rv, model);
    end

    // R2: no tick, count holds
    repeat (5) @(negedge clk);
    read64(rv);
    chk("R2 hold", rv, model);

    // R6: write with a tick in the same clock uses old increment first
    wr_en_i = 1'b1; wr_data_i = 32'h0000_1000; tick_i = 1'b1;
    @(negedge clk);
    wr_en_i = 1'b0;
    @(negedge clk);
    tick_i = 1'b0;
    model = model + 64'h00CC_CCCC + 64'h1000;
    read64(rv);
    chk("R6 count", rv, model);
    chk("R6 inc", 64'(inc_o), 64'h1000);

    // R5: wide write is masked
    write_inc(32'hFFFF_FFFF);
    chk("R5 mask", 64'(inc_o), 64'h00FF_FFFF);

    // R7: high word comes from the snapshot taken at the low read
    rd_en_i = 1'b1; rd_hi_i = 1'b0;
    @(negedge clk);
    lo_part = rd_data_o;
    rd_en_i = 1'b0;
    snap = model;
    chk("R7 low", 64'(lo_part), 64'(snap[31:0]));
    ticks(300);
    model = model + 64'd300 * 64'h00FF_FFFF;
    rd_en_i = 1'b1; rd_hi_i = 1'b1;
    @(negedge clk);
    rd_en_i = 1'b0; rd_hi_i = 1'b0;
    chk("R7 high from snapshot", 64'(rd_data_o), 64'(snap[63:32]));
    read64(rv);
    chk("R7 live", rv, model);

    // R8: write beats a simultaneous speed change and persists
    speed_i = 2'd2;
    write_inc(32'h0012_3456);
    repeat (3) @(negedge clk);
    chk("R8 inc", 64'(inc_o), 64'h0012_3456);
    chk("R8 shift", 64'(shift_o), 64'd17);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule